// File: doc/BRIEF.md
# SPI Master/Slave Controller with Mode Fault

This block is a serial peripheral interface controller that moves 8-bit characters, most-significant bit first, and can work either as the bus master or as a slave. As master it makes the serial clock from a programmable divider of the system clock and drives the data-out line. As slave it follows an external serial clock. It drives its data-out line only while an active-low select input is held low.

Clock polarity and clock phase are programmable. The data pins and the clock pin are driven through separate output enables, so that pads outside the block can tri-state them. Software reaches the block through a small register port with four addresses. The status register reports transfer completion, a busy state and a mode fault. A mode fault is raised when a master sees its own select input pulled low.

The slave decodes select according to the phase setting. With phase 0, select frames every character, and bit edges that follow the eighth bit are ignored until select goes high again. With phase 1, select may stay low across any number of back-to-back characters.

Top module: `spi_port_ctrl`

## Requirements
- R1: Characters are 8 bits and are shifted most-significant bit first, both on the master data output and on the slave data output. The received byte is assembled with the first bit received in bit 7.
- R2: As master (control bit 0 = 1, control bit 1 = 1), `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0. As slave (control bit 1 = 0), `sck_oe` and `mosi_oe` are 0.
- R3: As an enabled slave, `miso_oe` is 1 exactly while `sel_n_in` is low, and 0 while `sel_n_in` is high.
- R4: With the enable bit (control bit 0) at 0, `sck_oe`, `mosi_oe` and `miso_oe` are all 0, whatever the select level.
- R5: An enabled master whose synchronised `sel_n_in` is low sets the fault bit (status bit 6). In the same cycle it clears control bit 1, aborts any transfer and drops `sck_oe` and `mosi_oe`.
- R6: The fault bit is cleared only by a read of status (address 1) while it is set, followed by a write to control (address 0). A control write that has no such read before it leaves the fault bit set.
- R7: `sck_out` rests at the polarity bit (control bit 2) when no character is in progress. With phase 0 (control bit 3 = 0), data is valid before the first edge, is sampled on odd edges and changes on even edges. With phase 1, data changes on odd edges (except the first odd edge of a character) and is sampled on even edges.
- R8: As master, each half-period of `sck_out` lasts divider/2 system clocks. The divider register is at address 3 and resets to 0. Divider values below 2 act as 2, and odd values are rounded down. Each character takes 16 clock edges.
- R9: The done bit (status bit 7) is set after the eighth bit is sampled. A read of the data register (address 2) clears it. A status read does not clear it.
- R10: A phase-0 slave starts each character when select falls. It ignores clock edges after the eighth bit until select rises, and loads the transmit byte while select is high.
- R11: A phase-1 slave with select held low sends characters back to back. The transmit byte for the next character is taken from the data register at the end of each character, and each received byte becomes readable at address 2.
- R12: Register map: address 0 is control (bit 0 enable, bit 1 master, bit 2 polarity, bit 3 phase) and reads back as written. Address 1 is status (bit 7 done, bit 6 fault, bit 5 busy). A write to address 2 sets the transmit byte and, for an idle master, starts a character. A read of address 2 returns the received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on status and data) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| sck_in | input | 1 | Serial clock from pad (slave) |
| sck_out | output | 1 | Serial clock to pad (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_in | input | 1 | Master-to-slave data from pad (slave) |
| mosi_out | output | 1 | Master-to-slave data to pad (master) |
| mosi_oe | output | 1 | Master-to-slave data output enable |
| miso_in | input | 1 | Slave-to-master data from pad (master) |
| miso_out | output | 1 | Slave-to-master data to pad (slave) |
| miso_oe | output | 1 | Slave-to-master data output enable |
| sel_n_in | input | 1 | Active-low select input |

## Verification
A bit counter that slips shows up as a received byte rotated by one or more places, and a done bit that comes one character early or late. Both can be seen on the first register read after the character ends. A shift register that loads at the wrong moment puts a wrong most-significant bit on the data pin before the first clock edge, or it repeats a bit in phase 1. The bench's pin-level capture sees this within one bit time. A lost fault state or a fault latch that clears too easily shows up at once on the output enables, and on the status read that follows the sequence of control writes.

// File: rtl/spi_port_pkg.sv
// Package: shared register addresses and the control word layout
// for the serial port controller. Assumes a 2-bit register address.
package spi_port_pkg;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_DATA   = 2'd2;
    localparam logic [1:0] ADDR_DIV    = 2'd3;

    // Control word, bit 0 (en) to bit 3 (cpha)
    typedef struct packed {
        logic cpha;
        logic cpol;
        logic master;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/spi_sck_gen.sv
// Master clock generator: on start it emits 2*BITS serial clock edges,
// each half-period lasting div/2 system clocks (minimum one). It flags
// the odd (lead) and even (trail) edges one cycle ahead, so that they
// act as strobes at the same edge where sck toggles. Assumes div is
// stable during a character.
module spi_sck_gen #(
    parameter int BITS  = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic             abort,
    output logic             sck,
    output logic             busy,
    output logic             lead,
    output logic             trail
);
    localparam int EDGES  = 2 * BITS;
    localparam int EDGE_W = $clog2(EDGES + 1);

    logic [DIV_W-1:0]  half;
    logic [DIV_W-1:0]  half_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic              tick;

    // Half-period length, with the divider floored at 2
    always_comb begin
        half = div >> 1;
        if (half == '0) half = DIV_W'(1);
    end

    assign tick  = busy && (half_cnt >= half - DIV_W'(1));
    assign lead  = tick && !edge_cnt[0];
    assign trail = tick &&  edge_cnt[0];

    // Edge sequencing: idle at cpol, 2*BITS toggles per character
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck      <= 1'b0;
            busy     <= 1'b0;
            half_cnt <= '0;
            edge_cnt <= '0;
        end else if (abort || (!busy && !start)) begin
            sck      <= cpol;
            busy     <= 1'b0;
            half_cnt <= '0;
            edge_cnt <= '0;
        end else if (!busy) begin
            sck      <= cpol;
            busy     <= 1'b1;
            half_cnt <= '0;
            edge_cnt <= '0;
        end else if (tick) begin
            half_cnt <= '0;
            sck      <= ~sck;
            edge_cnt <= edge_cnt + EDGE_W'(1);
            if (edge_cnt == EDGE_W'(EDGES - 1)) busy <= 1'b0;
        end else begin
            half_cnt <= half_cnt + DIV_W'(1);
        end
    end

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(cpol) && !$past(start)) |-> (sck == cpol)); // R7

endmodule

// File: rtl/spi_pin_sync.sv
// Pad input synchroniser for slave operation: clock, select and data
// each pass through STAGES flops. Clock edges are classified as lead
// (leaving the idle level cpol) or trail (returning to it). Assumes
// the external clock is slower than a few system clocks per half-period.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic sck_in,
    input  logic sel_n_in,
    input  logic sdi_in,
    output logic sel_n_s,
    output logic sdi_s,
    output logic lead,
    output logic trail
);
    localparam logic [2:0] RST_VAL = 3'b010; // {sck, sel_n, sdi}

    logic [2:0] stage [STAGES];
    logic       sck_prev;
    logic       sck_s;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // One synchroniser rank for the three pad inputs
        always_ff @(posedge clk) begin
            if (!rst_n)      stage[g] <= RST_VAL;
            else if (g == 0) stage[g] <= {sck_in, sel_n_in, sdi_in};
            else             stage[g] <= stage[g-1];
        end
    end

    assign sck_s   = stage[STAGES-1][2];
    assign sel_n_s = stage[STAGES-1][1];
    assign sdi_s   = stage[STAGES-1][0];

    // Previous synchronised clock, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign lead  = (sck_s != sck_prev) && (sck_s != cpol);
    assign trail = (sck_s != sck_prev) && (sck_s == cpol);

endmodule

// File: rtl/spi_shifter.sv
// Character shift core shared by master and slave. The transmit register
// presents its MSB on sdo and moves left on shift. The receive register
// takes sdi on sample. A bit counter marks the first and last samples,
// and word_valid pulses the cycle after the last sample.
// Assumes that load has priority over shift.
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    input  logic         sample,
    input  logic         sdi,
    output logic         sdo,
    output logic [W-1:0] rx_word,
    output logic         first,
    output logic         last,
    output logic         word_valid
);
    localparam int CNT_W = $clog2(W);

    logic [W-1:0]     tx_sh;
    logic [CNT_W-1:0] bit_cnt;

    assign sdo   = tx_sh[W-1];
    assign first = (bit_cnt == '0);
    assign last  = (bit_cnt == CNT_W'(W - 1));

    // Transmit register: parallel load or shift left
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_sh <= '0;
        else if (load)  tx_sh <= load_data;
        else if (shift) tx_sh <= {tx_sh[W-2:0], 1'b0};
    end

    // Receive register, bit counter and end-of-word pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word    <= '0;
            bit_cnt    <= '0;
            word_valid <= 1'b0;
        end else if (clr) begin
            bit_cnt    <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= sample && last;
            if (sample) begin
                rx_word <= {rx_word[W-2:0], sdi};
                bit_cnt <= last ? '0 : bit_cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/spi_port_ctrl.sv
// Serial peripheral controller, master or slave, with mode-fault detection.
// It holds the registers, chooses the shift strobes for the mode and phase
// in use, and drives the pad enables. Assumes that in slave mode the
// external clock half-period spans at least STAGES+2 system clocks.
module spi_port_ctrl
    import spi_port_pkg::*;
#(
    parameter int CHAR_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [CHAR_BITS-1:0] reg_wdata,
    output logic [CHAR_BITS-1:0] reg_rdata,
    input  logic                 sck_in,
    output logic                 sck_out,
    output logic                 sck_oe,
    input  logic                 mosi_in,
    output logic                 mosi_out,
    output logic                 mosi_oe,
    input  logic                 miso_in,
    output logic                 miso_out,
    output logic                 miso_oe,
    input  logic                 sel_n_in
);
    localparam int ST_DONE  = CHAR_BITS - 1;
    localparam int ST_FAULT = CHAR_BITS - 2;
    localparam int ST_BUSY  = CHAR_BITS - 3;

    ctrl_t                ctrl;
    logic [CHAR_BITS-1:0] div_q, tx_hold, rx_q;
    logic                 done_q, fault_q, fault_armed, slave_hold;
    logic                 is_master, is_slave, fault_now;
    logic                 wr_ctrl, wr_data, wr_div, rd_status, rd_data;
    logic                 start, busy, m_lead, m_trail;
    logic                 sel_n_s, mosi_s, s_lead, s_trail, s_active;
    logic                 sh_clr, sh_load, sh_shift, sh_sample, sh_sdi;
    logic                 sh_sdo, sh_first, sh_last, word_valid;
    logic [CHAR_BITS-1:0] sh_load_data, rx_word;

    assign is_master = ctrl.en && ctrl.master;
    assign is_slave  = ctrl.en && !ctrl.master;
    assign fault_now = is_master && !sel_n_s;

    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_data   = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_div    = reg_wr && (reg_addr == ADDR_DIV);
    assign rd_status = reg_rd && (reg_addr == ADDR_STATUS);
    assign rd_data   = reg_rd && (reg_addr == ADDR_DATA);

    assign start = wr_data && is_master && !busy && !fault_now;

    spi_sck_gen #(.BITS(CHAR_BITS), .DIV_W(CHAR_BITS)) u_sck_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .cpol  (ctrl.cpol),
        .div   (div_q),
        .start (start),
        .abort (fault_now || !is_master),
        .sck   (sck_out),
        .busy  (busy),
        .lead  (m_lead),
        .trail (m_trail)
    );

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol     (ctrl.cpol),
        .sck_in   (sck_in),
        .sel_n_in (sel_n_in),
        .sdi_in   (mosi_in),
        .sel_n_s  (sel_n_s),
        .sdi_s    (mosi_s),
        .lead     (s_lead),
        .trail    (s_trail)
    );

    // Strobe selection: the phase picks which edge samples and which shifts
    always_comb begin
        s_active = is_slave && !sel_n_s && !slave_hold;
        if (is_master) begin
            sh_sample = ctrl.cpha ? m_trail : m_lead;
            sh_shift  = ctrl.cpha ? (m_lead && !sh_first) : m_trail;
            sh_sdi    = miso_in;
        end else begin
            sh_sample = s_active && (ctrl.cpha ? s_trail : s_lead);
            sh_shift  = s_active && (ctrl.cpha ? (s_lead && !sh_first) : s_trail);
            sh_sdi    = mosi_s;
        end
        sh_clr       = start || !ctrl.en || fault_now || (is_slave && sel_n_s);
        sh_load      = start || (is_slave && sel_n_s) ||
                       (is_slave && ctrl.cpha && sh_sample && sh_last);
        sh_load_data = start ? reg_wdata : tx_hold;
    end

    spi_shifter #(.W(CHAR_BITS)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (sh_clr),
        .load       (sh_load),
        .load_data  (sh_load_data),
        .shift      (sh_shift),
        .sample     (sh_sample),
        .sdi        (sh_sdi),
        .sdo        (sh_sdo),
        .rx_word    (rx_word),
        .first      (sh_first),
        .last       (sh_last),
        .word_valid (word_valid)
    );

    // Control register; a mode fault forces the master bit low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl)   ctrl <= ctrl_t'(reg_wdata[3:0]);
            if (fault_now) ctrl.master <= 1'b0;
        end
    end

    // Fault flag: set by the select pin, cleared by a status read then a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q     <= 1'b0;
            fault_armed <= 1'b0;
        end else begin
            if (fault_now) begin
                fault_q     <= 1'b1;
                fault_armed <= 1'b0;
            end else if (wr_ctrl) begin
                if (fault_armed) fault_q <= 1'b0;
                fault_armed <= 1'b0;
            end else if (rd_status && fault_q) begin
                fault_armed <= 1'b1;
            end
        end
    end

    // Transmit holding byte and divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            div_q   <= '0;
        end else begin
            if (wr_data) tx_hold <= reg_wdata;
            if (wr_div)  div_q   <= reg_wdata;
        end
    end

    // Received byte and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q   <= '0;
            done_q <= 1'b0;
        end else if (word_valid) begin
            rx_q   <= rx_word;
            done_q <= 1'b1;
        end else if (rd_data) begin
            done_q <= 1'b0;
        end
    end

    // Phase-0 slave: block further edges after a full character until deselect
    always_ff @(posedge clk) begin
        if (!rst_n)                                            slave_hold <= 1'b0;
        else if (sel_n_s || !is_slave)                         slave_hold <= 1'b0;
        else if (!ctrl.cpha && s_active && sh_sample && sh_last) slave_hold <= 1'b1;
    end

    // Pad drive and enables
    assign mosi_out = sh_sdo;
    assign miso_out = sh_sdo;
    assign sck_oe   = is_master;
    assign mosi_oe  = is_master;
    assign miso_oe  = is_slave && !sel_n_in;

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:   reg_rdata[3:0] = ctrl;
            ADDR_STATUS: begin
                reg_rdata[ST_DONE]  = done_q;
                reg_rdata[ST_FAULT] = fault_q;
                reg_rdata[ST_BUSY]  = busy;
            end
            ADDR_DATA:   reg_rdata = rx_q;
            default:     reg_rdata = div_q;
        endcase
    end

    AST_NO_PIN_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (!mosi_oe && !sck_oe)); // R2
    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_in |-> !miso_oe); // R3
    AST_FAULT_DROPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> (!sck_oe && !mosi_oe && !busy)); // R5
    AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(word_valid)); // R9

endmodule

// File: tb/test_spi_port_ctrl.sv
`timescale 1ns/1ps
module test_spi_port_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0, sel_n_in = 1'b1;
    logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int half_meas;

    always #4 clk = ~clk;

    spi_port_ctrl i_spi_port_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .sel_n_in(sel_n_in)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_not_busy();
        logic [7:0] st;
        for (int i = 0; i < 400; i++) begin
            reg_read(2'd1, st);
            if (!st[5]) break;
        end
    endtask

    // Bench slave answering the DUT master
    task automatic ext_slave(input logic cpol, input logic cpha,
                             input logic [7:0] txb, output logic [7:0] got);
        realtime t0, t1;
        got = '0;
        for (int i = 0; i < 8; i++) begin
            @(sck_out); #1;
            if (i == 0) t0 = $realtime;
            if (cpha) miso_in = txb[7-i];
            else      got = {got[6:0], mosi_out};
            @(sck_out); #1;
            if (i == 0) t1 = $realtime;
            if (cpha)       got = {got[6:0], mosi_out};
            else if (i < 7) miso_in = txb[6-i];
        end
        half_meas = int'((t1 - t0) / 8.0);
    endtask

    task automatic test_reset();
        logic [7:0] d;
        reg_read(2'd0, d); chk("R12 ctrl reset", d, 0);
        reg_read(2'd1, d); chk("R9 status reset", d, 0);
        reg_read(2'd3, d); chk("R8 divider reset", d, 0);
        chk("R4 oe at reset", {sck_oe, mosi_oe, miso_oe}, 0);
        chk("R7 sck idle at reset", sck_out, 0);
    endtask

    task automatic test_master(input logic cpol, input logic cpha, input logic [7:0] dv,
                               input int exp_half, input logic [7:0] txb, input logic [7:0] sb);
        logic [7:0] d, got;
        reg_write(2'd3, dv);
        reg_write(2'd0, {4'b0, cpha, cpol, 2'b11});
        idle(3);
        reg_read(2'd0, d); chk("R12 ctrl readback", d, {4'b0, cpha, cpol, 2'b11});
        chk("R2 master enables", {sck_oe, mosi_oe, miso_oe}, 3'b110);
        chk("R7 sck idle before", sck_out, cpol);
        chk("R1 msb presented before first edge", mosi_out, 0);
        miso_in = cpha ? 1'b0 : sb[7];
        fork
            reg_write(2'd2, txb);
            ext_slave(cpol, cpha, sb, got);
        join
        wait_not_busy();
        chk("R1 master sends msb first", got, txb);
        chk("R8 half period cycles", half_meas, exp_half);
        chk("R7 sck idle after", sck_out, cpol);
        reg_read(2'd1, d); chk("R9 done set", d[7], 1);
        reg_read(2'd1, d); chk("R9 status read keeps done", d[7], 1);
        reg_read(2'd2, d); chk("R1 master receive", d, sb);
        reg_read(2'd1, d); chk("R9 done cleared by data read", d[7], 0);
    endtask

    task automatic test_fault();
        logic [7:0] d;
        reg_write(2'd3, 8'd4);
        reg_write(2'd0, 8'h03);
        idle(3);
        sel_n_in = 1'b0;
        idle(6);
        chk("R5 drive dropped", {sck_oe, mosi_oe}, 0);
        reg_read(2'd0, d); chk("R5 master bit cleared", d[1], 0);
        sel_n_in = 1'b1;
        idle(4);
        reg_write(2'd0, 8'h03);
        reg_read(2'd1, d); chk("R6 control write alone keeps fault", d[6], 1);
        reg_write(2'd0, 8'h03);
        reg_read(2'd1, d); chk("R6 fault cleared after read then write", d[6], 0);
        chk("R2 master drive restored", {sck_oe, mosi_oe}, 2'b11);
    endtask

    task automatic test_slave_cpha0(input logic cpol, input logic [7:0] txb, input logic [7:0] mb);
        logic [7:0] d, got;
        int H = 8;
        reg_write(2'd0, {5'b0, cpol, 2'b01});
        reg_write(2'd2, txb);
        sck_in = cpol;
        idle(6);
        chk("R3 deselected slave hi-z", miso_oe, 0);
        chk("R2 slave enables", {sck_oe, mosi_oe}, 0);
        @(negedge clk); sel_n_in = 1'b0;
        #1 chk("R3 selected slave drives", miso_oe, 1);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            mosi_in = mb[7-i];
            idle(H);
            sck_in = ~cpol;
            got = {got[6:0], miso_out};
            idle(H);
            sck_in = cpol;
        end
        idle(H);
        mosi_in = 1'b1;
        for (int i = 0; i < 2; i++) begin
            sck_in = ~cpol; idle(H); sck_in = cpol; idle(H);
        end
        sel_n_in = 1'b1;
        idle(6);
        chk("R1 slave sends msb first", got, txb);
        reg_read(2'd1, d); chk("R9 slave done", d[7], 1);
        reg_read(2'd2, d); chk("R10 extra edges ignored", d, mb);
    endtask

    task automatic test_slave_cpha1(input logic cpol, input logic [7:0] t1, input logic [7:0] t2,
                                    input logic [7:0] m1, input logic [7:0] m2);
        logic [7:0] d, got;
        int H = 8;
        reg_write(2'd0, {4'b0, 1'b1, cpol, 2'b01});
        reg_write(2'd2, t1);
        sck_in = cpol;
        idle(6);
        sel_n_in = 1'b0;
        idle(H);
        reg_write(2'd2, t2);
        for (int c = 0; c < 2; c++) begin
            got = '0;
            for (int i = 0; i < 8; i++) begin
                sck_in = ~cpol;
                mosi_in = (c == 0) ? m1[7-i] : m2[7-i];
                idle(H);
                got = {got[6:0], miso_out};
                sck_in = cpol;
                idle(H);
            end
            reg_read(2'd2, d);
            if (c == 0) begin
                chk("R11 first byte sent", got, t1);
                chk("R11 first byte received", d, m1);
            end else begin
                chk("R11 back-to-back byte sent", got, t2);
                chk("R11 back-to-back byte received", d, m2);
            end
        end
        sel_n_in = 1'b1;
        idle(4);
    endtask

    task automatic test_disabled();
        reg_write(2'd0, 8'h00);
        sel_n_in = 1'b0;
        idle(5);
        chk("R4 disabled no drive", {sck_oe, mosi_oe, miso_oe}, 0);
        sel_n_in = 1'b1;
        idle(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        test_reset();
        test_master(1'b0, 1'b0, 8'd4, 2, 8'hA5, 8'h3C);
        test_master(1'b1, 1'b1, 8'd6, 3, 8'h96, 8'h69);
        test_master(1'b0, 1'b1, 8'd1, 1, 8'h4E, 8'hB1);
        test_master(1'b1, 1'b0, 8'd7, 3, 8'h0F, 8'hF0);
        test_fault();
        test_slave_cpha0(1'b0, 8'hC3, 8'h5A);
        test_slave_cpha0(1'b1, 8'h81, 8'h7E);
        test_slave_cpha1(1'b0, 8'h5A, 8'h81, 8'h11, 8'hE2);
        test_slave_cpha1(1'b1, 8'hB4, 8'h2D, 8'hC7, 8'h38);
        test_disabled();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule